// File: doc/BRIEF.md
# Stop-Mode Clock Wake-Up Sequencer

This block owns the system clock around a low-power stop mode. Running on the fast oscillator clock, it produces two clock-enable strobes: a core strobe at one quarter of the oscillator rate and a peripheral strobe at one sixteenth. It also drives the oscillator enable, the system clock gate enable and a clock-ready flag. On power-on reset, and again on every exit from stop, it runs one fixed restart sequence before it declares the clock ready:

1. Open the clock gate.
2. Clear the warm-up count and restart the divider.
3. Wait out the flash power-up time.
4. Count the warm-up core strobes.

When stop is requested, the front-end power state decides what happens to the oscillator:

- **Front end active:** the oscillator keeps running.
- **Front end powered down:** the oscillator is switched off.
- **Front end in standby:** the oscillator is duty-cycled on a free-running low-power tick, so the front end can take samples. A threshold hit during a sample window raises a one-cycle wake interrupt and starts the restart sequence.

The state machine has nine states:

- **Restart states:** UNGATE → CLEAR → FLASH (on flash count done) → WARM (on warm-up count done) → RUN.
- **Leaving RUN:** an armed stop request goes to HOLD (front end active), DOWN (front-end code 6) or DOZE (front-end code 5).
- **Standby cycling:** DOZE → SAMPLE after the off-time ticks, and SAMPLE → DOZE after the on-time ticks.
- **Changes inside stop:** any stop state re-targets HOLD, DOWN or DOZE when the front-end code changes.
- **Leaving stop:** every stop state returns to UNGATE when the stop request drops. HOLD and SAMPLE also return to UNGATE on a threshold hit, and that return raises the interrupt.

Top module: `stopclk_seq`

## Requirements
- R1: While rst_n is low: osc_en=1, clk_gate_en=1, clk_ready=0, wake_irq=0, core_stb=0. Releasing reset starts the restart sequence.
- R2: During FLASH, WARM and RUN, core_stb pulses once every CORE_DIV (4) clocks. periph_stb pulses on every PERIPH_DIV-th (4th) core pulse. Both strobes are 0 in every other state. The divider restarts from zero in CLEAR, so the first core pulse comes CORE_DIV clocks after CLEAR.
- R3: clk_ready rises exactly T edges after reset release. T = 2 + FLASH_CYCLES + the clocks up to and including the WARM_TICKS-th core pulse after the flash wait. With the defaults (200, 8, 4), T = 234.
- R4: clk_ready falls on the first edge at which an armed stop_req is seen in RUN. In every stop state, clk_gate_en, core_stb and periph_stb are 0.
- R5: In stop with fe_mode other than 5 (standby) or 6 (powered down), osc_en stays 1. osc_en is 0 only in stop with fe_mode 5 or 6.
- R6: In stop with fe_mode=6, osc_en stays 0 regardless of lp_tick. No sampling happens, and thr_hit is ignored.
- R7: In stop with fe_mode=5, osc_en is 0 for SAMPLE_PERIOD−SAMPLE_ON lp_tick pulses, then 1 for SAMPLE_ON pulses, and this repeats.
- R8: thr_hit=1 in a sample window (or in stop with the front end active) gives wake_irq=1 for exactly one cycle, on the next edge, together with entry to the restart sequence. thr_hit=1 while the oscillator is off has no effect.
- R9: A fall of stop_req in stop restarts the sequence, and clk_ready rises T+1 edges later.
- R10: A stop_req held high through an interrupt wake is not acted on until it has been low for at least one cycle.
- R11: A stop_req raised during the restart sequence is acted on only once RUN is reached, which gives one cycle of clk_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator-domain clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| stop_req | input | 1 | CPU stop request (level) |
| fe_mode | input | 3 | Front-end power state: 5 standby, 6 powered down, others active |
| thr_hit | input | 1 | Front-end threshold condition met |
| lp_tick | input | 1 | Free-running low-power tick pulse |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | System clock gate open |
| clk_ready | output | 1 | Clock released after warm-up |
| core_stb | output | 1 | Core clock enable strobe (÷4) |
| periph_stb | output | 1 | Peripheral clock enable strobe (÷16) |
| wake_irq | output | 1 | One-cycle wake interrupt |

## Verification
The embedded properties guard the following on every cycle:
- clk_ready can only rise out of warm-up on a core strobe, and it drops after an accepted stop.
- The oscillator only switches off in stop with the front end in standby or powered down.
- The interrupt is a single pulse caused by a threshold hit while the oscillator ran.
- The counters never pass their limits, and core strobes never come back to back.

Only the directed scenarios can show the rest: the exact restart latency after reset and after a stop exit, the doze and sample tick counts, threshold hits ignored while the oscillator is off, and a held stop request that is not honoured again.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    typedef enum logic [3:0] {
        ST_UNGATE,
        ST_CLEAR,
        ST_FLASH,
        ST_WARM,
        ST_RUN,
        ST_HOLD,
        ST_DOWN,
        ST_DOZE,
        ST_SAMPLE
    } seq_state_t;

    localparam logic [2:0] FE_STANDBY = 3'd5;
    localparam logic [2:0] FE_PWRDN   = 3'd6;

    // Stop state chosen from the front-end power code
    function automatic seq_state_t stop_target(input logic [2:0] fe);
        if (fe == FE_PWRDN)
            return ST_DOWN;
        else if (fe == FE_STANDBY)
            return ST_DOZE;
        else
            return ST_HOLD;
    endfunction

endpackage

// File: rtl/stopclk_cnt.sv
module stopclk_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] cnt;

    assign done = inc && (cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= done ? '0 : cnt + 1'b1;
    end

    // R3: count stays below its limit while in use
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt < limit));

endmodule

// File: rtl/stopclk_div.sv
module stopclk_div #(
    parameter int CORE_DIV   = 4,
    parameter int PERIPH_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic core_stb,
    output logic periph_stb
);

    localparam int NSTAGE = 2;

    logic [NSTAGE:0] en;
    assign en[0] = run;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        localparam int R  = (g == 0) ? CORE_DIV : PERIPH_DIV;
        localparam int SW = (R > 1) ? $clog2(R) : 1;
        logic [SW-1:0] cnt;
        logic          wrap;

        assign wrap    = (cnt == SW'(R - 1));
        assign en[g+1] = en[g] && wrap;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt <= '0;
            else if (!run)
                cnt <= '0;
            else if (en[g])
                cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    assign core_stb   = en[1];
    assign periph_stb = en[2];

    // R2: core strobes are never on adjacent cycles
    p_core_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_stb |=> !core_stb);

endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq
    import stopclk_pkg::*;
#(
    parameter int FLASH_CYCLES  = 200,
    parameter int WARM_TICKS    = 8,
    parameter int CORE_DIV      = 4,
    parameter int PERIPH_DIV    = 4,
    parameter int SAMPLE_PERIOD = 1024,
    parameter int SAMPLE_ON     = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic [2:0] fe_mode,
    input  logic       thr_hit,
    input  logic       lp_tick,
    output logic       osc_en,
    output logic       clk_gate_en,
    output logic       clk_ready,
    output logic       core_stb,
    output logic       periph_stb,
    output logic       wake_irq
);

    localparam int FW         = $clog2(FLASH_CYCLES + 1);
    localparam int WW         = $clog2(WARM_TICKS + 1);
    localparam int LW         = $clog2(SAMPLE_PERIOD + 1);
    localparam int DOZE_TICKS = SAMPLE_PERIOD - SAMPLE_ON;

    seq_state_t    state, state_n;
    logic          armed;
    logic          wake_thr;
    logic          div_run;
    logic          flash_done, warm_done, lp_done;
    logic          lp_clr;
    logic [LW-1:0] lp_limit;
    logic          in_stop;

    // ---------------- sub-blocks ----------------
    assign div_run = (state == ST_FLASH) || (state == ST_WARM) || (state == ST_RUN);

    stopclk_div #(
        .CORE_DIV   (CORE_DIV),
        .PERIPH_DIV (PERIPH_DIV)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (div_run),
        .core_stb   (core_stb),
        .periph_stb (periph_stb)
    );

    stopclk_cnt #(.W(FW)) u_flash_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_FLASH),
        .inc   (1'b1),
        .limit (FW'(FLASH_CYCLES)),
        .done  (flash_done)
    );

    stopclk_cnt #(.W(WW)) u_warm_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_WARM),
        .inc   (core_stb),
        .limit (WW'(WARM_TICKS)),
        .done  (warm_done)
    );

    assign lp_limit = (state == ST_SAMPLE) ? LW'(SAMPLE_ON) : LW'(DOZE_TICKS);
    assign lp_clr   = (state_n != state) || !((state == ST_DOZE) || (state == ST_SAMPLE));

    stopclk_cnt #(.W(LW)) u_lp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lp_clr),
        .inc   (lp_tick),
        .limit (lp_limit),
        .done  (lp_done)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_UNGATE;
            armed    <= 1'b1;
            wake_irq <= 1'b0;
        end else begin
            state    <= state_n;
            wake_irq <= wake_thr;
            if (wake_thr)
                armed <= 1'b0;
            else if (!stop_req)
                armed <= 1'b1;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n  = state;
        wake_thr = 1'b0;
        unique case (state)
            ST_UNGATE: state_n = ST_CLEAR;
            ST_CLEAR:  state_n = ST_FLASH;
            ST_FLASH:  if (flash_done) state_n = ST_WARM;
            ST_WARM:   if (warm_done)  state_n = ST_RUN;
            ST_RUN:    if (stop_req && armed) state_n = stop_target(fe_mode);
            ST_HOLD: begin
                if (thr_hit) begin
                    wake_thr = 1'b1;
                    state_n  = ST_UNGATE;
                end else if (!stop_req)
                    state_n = ST_UNGATE;
                else
                    state_n = stop_target(fe_mode);
            end
            ST_DOWN: begin
                if (!stop_req)
                    state_n = ST_UNGATE;
                else
                    state_n = stop_target(fe_mode);
            end
            ST_DOZE: begin
                if (!stop_req)
                    state_n = ST_UNGATE;
                else if (fe_mode != FE_STANDBY)
                    state_n = stop_target(fe_mode);
                else if (lp_done)
                    state_n = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (thr_hit) begin
                    wake_thr = 1'b1;
                    state_n  = ST_UNGATE;
                end else if (!stop_req)
                    state_n = ST_UNGATE;
                else if (fe_mode != FE_STANDBY)
                    state_n = stop_target(fe_mode);
                else if (lp_done)
                    state_n = ST_DOZE;
            end
            default: state_n = ST_UNGATE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_stop     = (state == ST_HOLD) || (state == ST_DOWN) ||
                      (state == ST_DOZE) || (state == ST_SAMPLE);
        osc_en      = !((state == ST_DOZE) || (state == ST_DOWN));
        clk_gate_en = !in_stop;
        clk_ready   = (state == ST_RUN);
    end

    // ---------------- assertions ----------------
    // R3: ready only rises out of warm-up on a core strobe
    p_ready_after_warm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ready) |-> ($past(state) == ST_WARM) && $past(core_stb));

    // R4: accepted stop drops ready on the next edge
    p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && stop_req && armed) |=> !clk_ready && !clk_gate_en);

    // R5: oscillator switches off only in stop with standby or power-down
    p_osc_off_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(stop_req) &&
                          (($past(fe_mode) == FE_STANDBY) || ($past(fe_mode) == FE_PWRDN)));

    // R8: wake interrupt is a single-cycle pulse
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    // R8: interrupt caused by a threshold hit while stopped with oscillator on
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> $past(thr_hit) && $past(osc_en) && !$past(clk_gate_en));

    // R9: stop release always restarts the sequence
    p_release_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && !stop_req) |=> (state == ST_UNGATE));

endmodule

// File: tb/stopclk_seq_test.sv
`timescale 1ns/1ps
module stopclk_seq_test;

    localparam int F      = 200;
    localparam int W      = 8;
    localparam int CDIV   = 4;
    localparam int PDIV   = 4;
    localparam int PERIOD = 16;
    localparam int ON     = 4;
    localparam int OFFSET = (CDIV - 1 - (F % CDIV) + CDIV) % CDIV;
    localparam int T      = 2 + F + OFFSET + CDIV * (W - 1) + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic [2:0] fe_mode = 3'd0;
    logic       thr_hit = 1'b0;
    logic       lp_tick = 1'b0;
    logic       osc_en, clk_gate_en, clk_ready, core_stb, periph_stb, wake_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stopclk_seq #(
        .FLASH_CYCLES  (F),
        .WARM_TICKS    (W),
        .CORE_DIV      (CDIV),
        .PERIPH_DIV    (PDIV),
        .SAMPLE_PERIOD (PERIOD),
        .SAMPLE_ON     (ON)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .fe_mode     (fe_mode),
        .thr_hit     (thr_hit),
        .lp_tick     (lp_tick),
        .osc_en      (osc_en),
        .clk_gate_en (clk_gate_en),
        .clk_ready   (clk_ready),
        .core_stb    (core_stb),
        .periph_stb  (periph_stb),
        .wake_irq    (wake_irq)
    );

    // low-power tick: one pulse every 3 clocks, changed just after the edge
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #1;
            lp_tick = (ph == 2);
            ph = (ph + 1) % 3;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!clk_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_ticks(input bit level, output int ticks);
        int guard = 0;
        ticks = 0;
        while (osc_en == level && guard < 500) begin
            if (lp_tick) ticks++;
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_reset();
        int n;
        rst_n = 1'b0; stop_req = 1'b0; fe_mode = 3'd0; thr_hit = 1'b0;
        repeat (3) @(negedge clk);
        chk(osc_en == 1 && clk_gate_en == 1, "R1", "reset osc/gate", {osc_en, clk_gate_en}, 3);
        chk(clk_ready == 0 && wake_irq == 0 && core_stb == 0, "R1", "reset ready/irq/stb",
            {clk_ready, wake_irq, core_stb}, 0);
        rst_n = 1'b1;
        wait_ready(n);
        chk(n == T, "R3", "ready latency after reset", n, T);
    endtask

    task automatic t_divider();
        int nc = 0, np = 0, bad = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (core_stb) nc++;
            if (periph_stb) np++;
            if (periph_stb && !core_stb) bad++;
        end
        chk(nc == 64 / CDIV, "R2", "core strobes in 64", nc, 64 / CDIV);
        chk(np == 64 / (CDIV * PDIV), "R2", "periph strobes in 64", np, 64 / (CDIV * PDIV));
        chk(bad == 0, "R2", "periph without core", bad, 0);
    endtask

    task automatic release_and_time(input string req);
        int n;
        stop_req = 1'b0;
        wait_ready(n);
        chk(n == T + 1, req, "ready latency after stop exit", n, T + 1);
    endtask

    task automatic t_stop_active();
        int osc_low = 0, stb = 0;
        fe_mode = 3'd0;
        stop_req = 1'b1;
        @(negedge clk);
        chk(clk_ready == 0 && clk_gate_en == 0, "R4", "ready/gate after stop",
            {clk_ready, clk_gate_en}, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!osc_en) osc_low++;
            if (core_stb || periph_stb) stb++;
        end
        chk(osc_low == 0, "R5", "osc off cycles with front end active", osc_low, 0);
        chk(stb == 0, "R4", "strobes during stop", stb, 0);
        release_and_time("R9");
    endtask

    task automatic t_stop_powerdown();
        int osc_high = 0, irqs = 0;
        fe_mode = 3'd6;
        stop_req = 1'b1;
        @(negedge clk);
        chk(osc_en == 0, "R6", "osc after stop in power-down", osc_en, 0);
        for (int i = 0; i < 100; i++) begin
            thr_hit = (i == 50);
            @(negedge clk);
            if (osc_en) osc_high++;
            if (wake_irq) irqs++;
        end
        thr_hit = 1'b0;
        chk(osc_high == 0, "R6", "osc on cycles in power-down", osc_high, 0);
        chk(irqs == 0, "R6", "irq in power-down", irqs, 0);
        release_and_time("R9");
    endtask

    task automatic t_stop_standby();
        int ticks, n, drops = 0;
        fe_mode = 3'd5;
        stop_req = 1'b1;
        @(negedge clk);
        chk(osc_en == 0, "R7", "osc off at doze entry", osc_en, 0);
        count_ticks(1'b0, ticks);
        chk(ticks == PERIOD - ON, "R7", "doze ticks", ticks, PERIOD - ON);
        count_ticks(1'b1, ticks);
        chk(ticks == ON, "R7", "sample ticks", ticks, ON);
        // threshold while oscillator is off: ignored
        repeat (2) @(negedge clk);
        thr_hit = 1'b1;
        @(negedge clk);
        thr_hit = 1'b0;
        chk(wake_irq == 0 && osc_en == 0, "R8", "irq/osc after hit while off",
            {wake_irq, osc_en}, 0);
        // wait for next sample window and hit
        while (!osc_en) @(negedge clk);
        thr_hit = 1'b1;
        @(negedge clk);
        thr_hit = 1'b0;
        chk(wake_irq == 1 && clk_gate_en == 1, "R8", "irq/gate after sample hit",
            {wake_irq, clk_gate_en}, 3);
        @(negedge clk);
        chk(wake_irq == 0, "R8", "irq pulse width", wake_irq, 0);
        wait_ready(n);
        chk(n == T - 1, "R8", "ready latency after irq wake", n, T - 1);
        // held stop request must not re-enter stop
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!clk_ready) drops++;
        end
        chk(drops == 0, "R10", "ready drops with held stop", drops, 0);
        stop_req = 1'b0;
        repeat (2) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        chk(clk_ready == 0, "R10", "ready after re-raised stop", clk_ready, 0);
        release_and_time("R9");
    endtask

    task automatic t_stop_during_boot();
        int n;
        rst_n = 1'b0; stop_req = 1'b0; fe_mode = 3'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        stop_req = 1'b1;
        wait_ready(n);
        chk(n == T - 10, "R11", "ready latency with early stop", n, T - 10);
        @(negedge clk);
        chk(clk_ready == 0, "R11", "ready one cycle then stop", clk_ready, 0);
        release_and_time("R9");
    endtask

    initial begin
        do_reset();
        t_divider();
        t_stop_active();
        t_stop_powerdown();
        t_stop_standby();
        t_stop_during_boot();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule